// File: doc/BRIEF.md
# True-Colour Pixel Word Formatter

This block sits behind a 32-bit pixel input port that delivers one word per word-clock strobe. It converts each word into one or two pixels, each made of 8-bit red, green and blue values plus an 8-bit overlay index. Two packed 16-bit layouts are handled: one with a single overlay bit and three 5-bit colours, and one with 5-bit red, 6-bit green and 5-bit blue. Each can carry one pixel per word or two pixels per word. Two full 32-bit layouts each carry four 8-bit fields, and the field order of one is the mirror image of the other.

Narrow colour fields are placed in the top bits of the 8-bit channel, and the bits below them are filled with zeros. In the single-overlay-bit layouts, the seven upper overlay bits come from a page input. The composed overlay is ANDed with a mask. When the masked overlay is zero, the true-colour channels drive the outputs. Otherwise the pixel is handed to the palette path: the colour channels read zero and the overlay output carries the masked index. A byte-order select reverses the pixel order in the two-per-word layouts and reverses the bytes of the word in the 32-bit layouts.

Top module: `tc_pixel_formatter`

## Requirements
- R1: While `pix_vld_o` is low, and during reset, `red_o`, `grn_o`, `blu_o` and `ovl_o` are 0 and `tc_o` is 0. Asserting reset drops all outputs to 0 at once.
- R2: In the one-pixel layouts (codes 0, 1, 4, 5, 6 and 7), a word sampled with `word_vld` high at clock edge E produces exactly one pixel. `pix_vld_o` is high only in the cycle after edge E+1.
- R3: In the two-pixel layouts (code 2 for the 1-5-5-5 layout, code 3 for 5-6-5) with `big_end`=0, bits 15:0 give the pixel valid after E+1 and bits 31:16 give the pixel valid after E+2. A new word must not be presented in the cycle that follows a two-pixel word.
- R4: In the 1-5-5-5 layouts (codes 0 and 2), bit 15 of the half is the overlay bit. Red is bits 14:10, green 9:5 and blue 4:0, and each is output as {field,3'b000}.
- R5: In the 5-6-5 layouts (codes 1 and 3), red is bits 15:11 as {field,3'b000}, green is bits 10:5 as {field,2'b00} and blue is bits 4:0 as {field,3'b000}. The overlay is 0, so the pixel is always true colour.
- R6: In the 1-5-5-5 layouts the overlay is {page_i[6:0], bit15}. In every layout, the value compared against zero and output on `ovl_o` is the overlay AND `mask_i`.
- R7: `tc_o`=1 and the colours are driven when the masked overlay is 0. Otherwise `tc_o`=0, the colours are 0 and `ovl_o` is the masked overlay.
- R8: Code 4 reads blue from bits 7:0, green from 15:8, red from 23:16 and overlay from 31:24. Code 5 reads overlay from bits 7:0, red from 15:8, green from 23:16 and blue from 31:24.
- R9: With `big_end`=1, the two-pixel layouts output bits 31:16 first and bits 15:0 second. In the 32-bit layouts, the four bytes of the word are reversed before the fields are read. The one-pixel 16-bit layouts always use bits 15:0.
- R10: The reserved codes 6 and 7 decode as code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| word_vld | input | 1 | A pixel word is present on `word_in` |
| word_in | input | 32 | Pixel port word |
| fmt_sel | input | 3 | Layout code (0..5, with 6 and 7 reserved), captured with the word |
| big_end | input | 1 | Byte-order select, captured with the word |
| page_i | input | 7 | Upper overlay bits for the 1-5-5-5 layouts |
| mask_i | input | 8 | Mask applied to the overlay |
| pix_vld_o | output | 1 | Pixel output valid |
| red_o | output | 8 | Red channel |
| grn_o | output | 8 | Green channel |
| blu_o | output | 8 | Blue channel |
| ovl_o | output | 8 | Masked overlay / palette index |
| tc_o | output | 1 | 1 = true-colour pixel, 0 = palette pixel |

## Verification
The bench targets the order of the two halves under both byte orders. A design that swapped them would show green where red was expected. It checks the zero fill of the 6-bit green field against the 5-bit fields, where a design using the 5-bit fill for green would lose a bit or shift it. It covers the overlay built from the page bits with and without masking, where a wrong gate would pass colours while the overlay is non-zero, and the byte reversal of both 32-bit layouts, where a wrong reversal would output the colour bytes in the wrong order. It also checks that one-pixel words do not produce a second pixel, and that a reset during a two-pixel word clears the outputs.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  localparam int CH_W   = 8;
  localparam int WORD_W = 4 * CH_W;
  localparam int HALF_W = WORD_W / 2;
  localparam int PAGE_W = CH_W - 1;

  typedef enum logic [2:0] {
    FMT_1555   = 3'd0,
    FMT_565    = 3'd1,
    FMT_1555X2 = 3'd2,
    FMT_565X2  = 3'd3,
    FMT_W32_A  = 3'd4,
    FMT_W32_B  = 3'd5
  } fmt_e;

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] grn;
    logic [CH_W-1:0] blu;
    logic [CH_W-1:0] ovl;
  } rgbo_t;

  function automatic logic is_dual(input logic [2:0] f);
    return (f == FMT_1555X2) || (f == FMT_565X2);
  endfunction

  function automatic logic is_565(input logic [2:0] f);
    return (f == FMT_565) || (f == FMT_565X2);
  endfunction

  function automatic logic is_w16(input logic [2:0] f);
    return (f != FMT_W32_A) && (f != FMT_W32_B);
  endfunction
endpackage

// File: rtl/tcf_rst_sync.sv
module tcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/tcf_beat_seq.sv
module tcf_beat_seq
  import tcf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  input  logic [2:0]        fmt_in,
  input  logic              be_in,
  output logic              beat_vld,
  output logic              beat_upper,
  output logic [WORD_W-1:0] beat_word,
  output logic [2:0]        beat_fmt,
  output logic              beat_be
);
  logic              vld_q, vld_d;
  logic              hi_q, hi_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [2:0]        fmt_q, fmt_d;
  logic              be_q, be_d;
  logic              load_en;

  assign load_en = word_vld;

  always_comb begin
    word_d = word_q;
    fmt_d  = fmt_q;
    be_d   = be_q;
    vld_d  = 1'b0;
    hi_d   = 1'b0;
    if (load_en) begin
      word_d = word_in;
      fmt_d  = fmt_in;
      be_d   = be_in;
      vld_d  = 1'b1;
    end else if (vld_q && !hi_q && is_dual(fmt_q)) begin
      vld_d = 1'b1;
      hi_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hi_q   <= 1'b0;
      word_q <= '0;
      fmt_q  <= '0;
      be_q   <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      hi_q   <= hi_d;
      word_q <= word_d;
      fmt_q  <= fmt_d;
      be_q   <= be_d;
    end
  end

  // Which 16-bit half feeds the decoder on this beat
  always_comb begin
    if (is_dual(fmt_q)) beat_upper = hi_q ^ be_q;
    else                beat_upper = 1'b0;
  end

  assign beat_vld  = vld_q;
  assign beat_word = word_q;
  assign beat_fmt  = fmt_q;
  assign beat_be   = be_q;

  // R3: a two-pixel word always yields its second beat next cycle
  a_r3_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !hi_q && is_dual(fmt_q) && !word_vld) |=> (vld_q && hi_q));

  // R3: no new word may arrive while the second half is pending
  a_r3_word_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !hi_q && is_dual(fmt_q)) |-> !word_vld);

  // R2: one-pixel words produce a single beat
  a_r2_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !is_dual(fmt_q) && !word_vld) |=> !vld_q);
endmodule

// File: rtl/tcf_unpack.sv
module tcf_unpack
  import tcf_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              upper,
  input  logic [2:0]        fmt,
  input  logic              be,
  input  logic [PAGE_W-1:0] page,
  output rgbo_t             pix
);
  logic [HALF_W-1:0] half;
  logic [WORD_W-1:0] wrd;

  assign half = upper ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];

  // Byte reversal for the 32-bit layouts
  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_bswap
      assign wrd[gi*CH_W +: CH_W] = be ? word[(3-gi)*CH_W +: CH_W]
                                       : word[gi*CH_W +: CH_W];
    end
  endgenerate

  always_comb begin
    pix = '0;
    case (fmt)
      FMT_565, FMT_565X2: begin
        pix.red = {half[15:11], 3'b000};
        pix.grn = {half[10:5],  2'b00};
        pix.blu = {half[4:0],   3'b000};
        pix.ovl = '0;
      end
      FMT_W32_A: begin
        pix.blu = wrd[7:0];
        pix.grn = wrd[15:8];
        pix.red = wrd[23:16];
        pix.ovl = wrd[31:24];
      end
      FMT_W32_B: begin
        pix.ovl = wrd[7:0];
        pix.red = wrd[15:8];
        pix.grn = wrd[23:16];
        pix.blu = wrd[31:24];
      end
      default: begin
        pix.red = {half[14:10], 3'b000};
        pix.grn = {half[9:5],   3'b000};
        pix.blu = {half[4:0],   3'b000};
        pix.ovl = {page, half[15]};
      end
    endcase
  end
endmodule

// File: rtl/tcf_ovl_gate.sv
module tcf_ovl_gate
  import tcf_pkg::*;
(
  input  rgbo_t           raw,
  input  logic [CH_W-1:0] mask,
  output rgbo_t           gated,
  output logic            tc
);
  logic [CH_W-1:0] ovl_m;

  assign ovl_m = raw.ovl & mask;
  assign tc    = (ovl_m == '0);

  always_comb begin
    gated     = '0;
    gated.ovl = ovl_m;
    if (tc) begin
      gated.red = raw.red;
      gated.grn = raw.grn;
      gated.blu = raw.blu;
    end
  end
endmodule

// File: rtl/tc_pixel_formatter.sv
module tc_pixel_formatter
  import tcf_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_vld,
  input  logic [31:0] word_in,
  input  logic [2:0]  fmt_sel,
  input  logic        big_end,
  input  logic [6:0]  page_i,
  input  logic [7:0]  mask_i,
  output logic        pix_vld_o,
  output logic [7:0]  red_o,
  output logic [7:0]  grn_o,
  output logic [7:0]  blu_o,
  output logic [7:0]  ovl_o,
  output logic        tc_o
);
  logic              srst_n;
  logic              beat_vld, beat_upper, beat_be;
  logic [WORD_W-1:0] beat_word;
  logic [2:0]        beat_fmt;
  rgbo_t             raw_pix, gated_pix;
  logic              gated_tc;

  rgbo_t      out_q, out_d;
  logic       vld_q, vld_d, tc_q, tc_d;
  logic [2:0] ofmt_q, ofmt_d;

  tcf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  tcf_beat_seq u_seq (
    .clk(clk), .rst_n(srst_n), .word_vld(word_vld), .word_in(word_in),
    .fmt_in(fmt_sel), .be_in(big_end), .beat_vld(beat_vld),
    .beat_upper(beat_upper), .beat_word(beat_word), .beat_fmt(beat_fmt),
    .beat_be(beat_be)
  );

  tcf_unpack u_unpack (
    .word(beat_word), .upper(beat_upper), .fmt(beat_fmt), .be(beat_be),
    .page(page_i), .pix(raw_pix)
  );

  tcf_ovl_gate u_gate (
    .raw(raw_pix), .mask(mask_i), .gated(gated_pix), .tc(gated_tc)
  );

  always_comb begin
    out_d  = '0;
    vld_d  = 1'b0;
    tc_d   = 1'b0;
    ofmt_d = ofmt_q;
    if (beat_vld) begin
      out_d  = gated_pix;
      vld_d  = 1'b1;
      tc_d   = gated_tc;
      ofmt_d = beat_fmt;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      out_q  <= '0;
      vld_q  <= 1'b0;
      tc_q   <= 1'b0;
      ofmt_q <= '0;
    end else begin
      out_q  <= out_d;
      vld_q  <= vld_d;
      tc_q   <= tc_d;
      ofmt_q <= ofmt_d;
    end
  end

  assign pix_vld_o = vld_q;
  assign red_o     = out_q.red;
  assign grn_o     = out_q.grn;
  assign blu_o     = out_q.blu;
  assign ovl_o     = out_q.ovl;
  assign tc_o      = tc_q;

  // R1: idle outputs are all zero
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!srst_n)
    !pix_vld_o |-> (red_o == 8'h00 && grn_o == 8'h00 && blu_o == 8'h00
                    && ovl_o == 8'h00 && !tc_o));

  // R7: palette pixels carry no colour and a non-zero index
  a_r7_palette_blank: assert property (@(posedge clk) disable iff (!srst_n)
    (pix_vld_o && !tc_o) |-> (red_o == 8'h00 && grn_o == 8'h00
                              && blu_o == 8'h00 && ovl_o != 8'h00));

  // R7: true-colour pixels have a zero overlay
  a_r7_tc_ovl_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (pix_vld_o && tc_o) |-> (ovl_o == 8'h00));

  // R4: 5-bit red and blue fields are zero-filled below
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (!srst_n)
    (pix_vld_o && is_w16(ofmt_q)) |-> (red_o[2:0] == 3'b000 && blu_o[2:0] == 3'b000));

  // R5: 6-bit green is zero-filled by two bits and the pixel is true colour
  a_r5_grn_fill: assert property (@(posedge clk) disable iff (!srst_n)
    (pix_vld_o && is_565(ofmt_q)) |-> (grn_o[1:0] == 2'b00 && tc_o));
endmodule

// File: tb/tc_pixel_formatter_tb.sv
module tc_pixel_formatter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  typedef struct packed {
    logic [2:0]  fmt;
    logic        be;
    logic [31:0] word;
    logic [6:0]  page;
    logic [7:0]  mask;
    logic [32:0] exp0;  // {red, grn, blu, ovl, tc}
    logic [32:0] exp1;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 1'b0, 32'hABCD7FFF, 7'h00, 8'hFF, {8'hF8,8'hF8,8'hF8,8'h00,1'b1}, 33'd0},
    '{3'd0, 1'b0, 32'h00008000, 7'h00, 8'hFF, {8'h00,8'h00,8'h00,8'h01,1'b0}, 33'd0},
    '{3'd0, 1'b0, 32'h12348421, 7'h00, 8'h00, {8'h08,8'h08,8'h08,8'h00,1'b1}, 33'd0},
    '{3'd0, 1'b0, 32'h00000000, 7'h55, 8'hFF, {8'h00,8'h00,8'h00,8'hAA,1'b0}, 33'd0},
    '{3'd1, 1'b0, 32'hFFFFF800, 7'h7F, 8'hFF, {8'hF8,8'h00,8'h00,8'h00,1'b1}, 33'd0},
    '{3'd1, 1'b0, 32'h000007FF, 7'h7F, 8'hFF, {8'h00,8'hFC,8'hF8,8'h00,1'b1}, 33'd0},
    '{3'd2, 1'b0, 32'h7C0003E0, 7'h00, 8'hFF, {8'h00,8'hF8,8'h00,8'h00,1'b1}, {8'hF8,8'h00,8'h00,8'h00,1'b1}},
    '{3'd2, 1'b1, 32'h7C0003E0, 7'h00, 8'hFF, {8'hF8,8'h00,8'h00,8'h00,1'b1}, {8'h00,8'hF8,8'h00,8'h00,1'b1}},
    '{3'd3, 1'b0, 32'h001FF800, 7'h00, 8'hFF, {8'hF8,8'h00,8'h00,8'h00,1'b1}, {8'h00,8'h00,8'hF8,8'h00,1'b1}},
    '{3'd4, 1'b0, 32'h00112233, 7'h00, 8'hFF, {8'h11,8'h22,8'h33,8'h00,1'b1}, 33'd0},
    '{3'd5, 1'b0, 32'h33221100, 7'h00, 8'hFF, {8'h11,8'h22,8'h33,8'h00,1'b1}, 33'd0},
    '{3'd4, 1'b1, 32'h33221100, 7'h00, 8'hFF, {8'h11,8'h22,8'h33,8'h00,1'b1}, 33'd0},
    '{3'd4, 1'b0, 32'h80112233, 7'h00, 8'h7F, {8'h11,8'h22,8'h33,8'h00,1'b1}, 33'd0},
    '{3'd4, 1'b0, 32'h80112233, 7'h00, 8'hFF, {8'h00,8'h00,8'h00,8'h80,1'b0}, 33'd0},
    '{3'd5, 1'b1, 32'h00112233, 7'h00, 8'hFF, {8'h11,8'h22,8'h33,8'h00,1'b1}, 33'd0},
    '{3'd6, 1'b0, 32'h00007FFF, 7'h00, 8'hFF, {8'hF8,8'hF8,8'hF8,8'h00,1'b1}, 33'd0}
  };

  logic        clk, rst_n, word_vld, big_end;
  logic [31:0] word_in;
  logic [2:0]  fmt_sel;
  logic [6:0]  page_i;
  logic [7:0]  mask_i;
  logic        pix_vld_o, tc_o;
  logic [7:0]  red_o, grn_o, blu_o, ovl_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  tc_pixel_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
    .fmt_sel(fmt_sel), .big_end(big_end), .page_i(page_i), .mask_i(mask_i),
    .pix_vld_o(pix_vld_o), .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o),
    .ovl_o(ovl_o), .tc_o(tc_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string colour_tag(input logic [2:0] f, input logic b);
    if ((f == 3'd2 || f == 3'd3) && b) return "R9";
    if (f == 3'd2 || f == 3'd3)        return "R3";
    if ((f == 3'd4 || f == 3'd5) && b) return "R9";
    if (f == 3'd4 || f == 3'd5)        return "R8";
    if (f == 3'd1)                     return "R5";
    if (f >= 3'd6)                     return "R10";
    return "R4";
  endfunction

  task automatic check(input string tag, input int idx,
                       input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s vec %0d: got %h expected %h", tag, idx, got, exp);
    end
  endtask

  task automatic check_pix(input vec_t v, input int idx, input logic [32:0] e);
    check("R2", idx, {31'd0, pix_vld_o}, 32'd1);
    check(colour_tag(v.fmt, v.be), idx, {8'h00, red_o, grn_o, blu_o}, {8'h00, e[32:9]});
    check("R6", idx, {24'd0, ovl_o}, {24'd0, e[8:1]});
    check("R7", idx, {31'd0, tc_o}, {31'd0, e[0]});
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    @(negedge clk);
    fmt_sel = v.fmt; big_end = v.be; page_i = v.page; mask_i = v.mask;
    word_in = v.word; word_vld = 1'b1;
    @(negedge clk);
    word_vld = 1'b0;
    @(negedge clk);
    check_pix(v, idx, v.exp0);
    if (v.fmt == 3'd2 || v.fmt == 3'd3) begin
      @(negedge clk);
      check_pix(v, idx, v.exp1);
    end
    @(negedge clk);
    // R1 / R2: nothing further after the last pixel of the word
    check("R1", idx, {pix_vld_o, tc_o, 6'd0, red_o, grn_o, ovl_o}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; word_vld = 1'b0; word_in = '0; fmt_sel = '0;
    big_end = 1'b0; page_i = '0; mask_i = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", -1, {pix_vld_o, tc_o, 6'd0, red_o, grn_o, blu_o}, 32'd0);
    check("R1", -1, {24'd0, ovl_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

    // R1: reset during a two-pixel word clears the outputs at once
    @(negedge clk);
    fmt_sel = 3'd2; big_end = 1'b0; page_i = 7'h00; mask_i = 8'hFF;
    word_in = 32'h7C0003E0; word_vld = 1'b1;
    @(negedge clk);
    word_vld = 1'b0;
    @(negedge clk);
    check("R3", 100, {24'd0, grn_o}, 32'h000000F8);
    #1 rst_n = 1'b0;
    #1;
    check("R1", 100, {pix_vld_o, tc_o, 6'd0, red_o, grn_o, blu_o}, 32'd0);
    @(negedge clk);
    check("R1", 101, {31'd0, pix_vld_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", 102, {pix_vld_o, tc_o, 6'd0, red_o, grn_o, ovl_o}, 32'd0);

    // R5: page and mask have no effect on 5-6-5 overlay
    @(negedge clk);
    fmt_sel = 3'd1; page_i = 7'h7F; mask_i = 8'hFF; word_in = 32'h0000FFFF; word_vld = 1'b1;
    @(negedge clk);
    word_vld = 1'b0;
    @(negedge clk);
    check("R5", 103, {7'd0, tc_o, red_o, grn_o, blu_o}, {7'd0, 1'b1, 24'hF8FCF8});

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule